// File: doc/BRIEF.md
# Extended Interrupt Router

This block takes a vector of level-sensitive interrupt sources and steers each one to a single processor core, and on that core to one of several parent interrupt lines. Sources are handled in groups of 32, one 32-bit word per group. Each source has an enable bit and a raw pending bit. Each core has its own status vector, whose bits record which sources are currently being presented to that core. A line map picks a parent line for each group. A core map picks a target core for each source.

Software reaches all of this through a 32-bit register window. Every request carries the number of the core that issued it. The status words are write-1-to-clear, and a status access always addresses the copy that belongs to the requesting core. Changing an enable bit or a core-map entry at run time moves interrupts that are already pending: they are re-presented or withdrawn. Each core's line outputs are the OR of the status bits routed to them, and they are registered.

Top module: `extirq_router`

## Requirements
- R1: A synchronous reset clears every enable bit, every map entry, raw pending state, every status bit and the response register. All `lines_out` bits are low after reset.
- R2: The line map holds one byte per group of 32 sources. Word at 0x100+4*w, byte b (bits 8b+7:8b) belongs to group 4w+b. The byte decodes to the position of its lowest set bit. A result of N_LINE or more, or an all-zero byte, selects line 0. Line-map changes take effect on the outputs immediately.
- R3: The core map holds one byte per source. Word at 0x200+4*w, byte b belongs to source 4w+b. With `core_direct_mode` low at write time, the byte decodes like the line map, with N_CORE as the limit and core 0 as the fallback. With it high, the low log2(N_CORE) bits of the byte give the core number directly.
- R4: A rising source sets its raw pending bit, and sets the status bit on its target core only if its enable bit is 1. A falling source clears the raw pending bit and the target core's status bit.
- R5: `lines_out[c*N_LINE+l]` is high exactly when some source mapped to core c, in a group mapped to line l, has its status bit set on core c. It follows the register write or input edge by one clock edge.
- R6: Enable words sit at 0x000+4*g. Writing one makes every source that goes from 0 to 1 and is raw pending assert on its core. Every source that goes from 1 to 0 is withdrawn from its core.
- R7: Status words sit at 0x300+4*g. Writing one clears, on the core named by `req_core` only, the status bits written as 1. Reading one returns that core's copy.
- R8: When a core-map entry changes for a raw pending source, the source leaves the old core and is raised on the new core if it is enabled. Rewriting an entry with the same decoded core changes nothing.
- R9: Only the 16 address bits are decoded. Read data appears on `rsp_data` one clock after the read request. Reads of offsets outside the four windows, or past the last word of a window, return 0. Writes to such offsets change nothing.
- R10: Enable, line-map and core-map words read back exactly as last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IRQ | Level interrupt sources |
| core_direct_mode | input | 1 | Core-map bytes are binary core numbers when high |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | Request is a write when high |
| req_addr | input | 16 | Byte address of the 32-bit register |
| req_wdata | input | 32 | Write data |
| req_core | input | log2(N_CORE) | Number of the requesting core |
| rsp_data | output | 32 | Read data, one cycle after the request |
| lines_out | output | N_CORE*N_LINE | Parent interrupt lines, core-major |

## Verification
The bench targets the run-time moves: a core-map rewrite while a source is pending, and a re-enable that must replay a source whose status was cleared by software but which is still raw pending. A design that forgot the old core would leave two lines high. One that ignored the pending bit would never re-raise the line. A clear issued by the wrong core must leave the other core's line high, and a disabled assertion must stay invisible until it is enabled. The bench also drives map bytes with no bit set, or with only an out-of-range bit set, to catch a decoder that picks the highest bit or wraps instead of falling back to 0. It then flips the direct-number mode to show the same byte lands on a different core.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  typedef enum logic [1:0] {
    WIN_ENABLE  = 2'd0,
    WIN_LINEMAP = 2'd1,
    WIN_COREMAP = 2'd2,
    WIN_STATUS  = 2'd3
  } win_e;

  // Position of the lowest set bit, or 8 when the byte is zero.
  function automatic logic [7:0] lowest_one(input logic [7:0] b);
    logic [7:0] r;
    r = 8'd8;
    for (int j = 7; j >= 0; j--) begin
      if (b[j]) r = 8'(j);
    end
    return r;
  endfunction

endpackage

// File: rtl/extirq_byte_decode.sv
module extirq_byte_decode
  import extirq_pkg::*;
#(
  parameter int unsigned OUT_W = 2,
  parameter int unsigned LIMIT = 4
) (
  input  logic [7:0]       code,
  input  logic             direct,
  output logic [OUT_W-1:0] idx
);

  logic [7:0] low;

  always_comb begin
    low = lowest_one(code);
    if (direct) begin
      idx = code[OUT_W-1:0];
    end else if (low < 8'(LIMIT)) begin
      idx = low[OUT_W-1:0];
    end else begin
      idx = '0;
    end
  end

endmodule

// File: rtl/extirq_cfg.sv
module extirq_cfg
  import extirq_pkg::*;
#(
  parameter int unsigned N_IRQ  = 64,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned N_LINE = 4,
  localparam int unsigned NG = N_IRQ / 32,
  localparam int unsigned CW = (N_CORE > 1) ? $clog2(N_CORE) : 1,
  localparam int unsigned LW = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  win_e                win,
  input  logic [5:0]          idx,
  input  logic [31:0]         wdata,
  input  logic                direct,
  output logic [31:0]         rd_word,
  output logic [N_IRQ-1:0]    en_q,
  output logic [N_IRQ-1:0]    en_d,
  output logic [NG*LW-1:0]    lmap_q,
  output logic [NG*LW-1:0]    lmap_d,
  output logic [N_IRQ*CW-1:0] cmap_q,
  output logic [N_IRQ*CW-1:0] cmap_d
);

  localparam int unsigned LMW = (NG + 3) / 4;
  localparam int unsigned CMW = N_IRQ / 4;

  logic [CW-1:0] core_code [4];
  logic [LW-1:0] line_code [4];
  logic [31:0]   lm_raw [LMW];
  logic [31:0]   cm_raw [CMW];
  logic          hit_en, hit_lm, hit_cm;

  // One decoder per byte lane; every map entry picks its lane.
  for (genvar b = 0; b < 4; b++) begin : g_lane
    extirq_byte_decode #(.OUT_W(CW), .LIMIT(N_CORE)) u_core_dec (
      .code(wdata[b*8 +: 8]), .direct(direct), .idx(core_code[b]));
    extirq_byte_decode #(.OUT_W(LW), .LIMIT(N_LINE)) u_line_dec (
      .code(wdata[b*8 +: 8]), .direct(1'b0), .idx(line_code[b]));
  end

  assign hit_en = wr_stb && (win == WIN_ENABLE);
  assign hit_lm = wr_stb && (win == WIN_LINEMAP);
  assign hit_cm = wr_stb && (win == WIN_COREMAP);

  always_comb begin
    en_d = en_q;
    for (int g = 0; g < NG; g++) begin
      if (hit_en && idx == 6'(g)) en_d[g*32 +: 32] = wdata;
    end
    lmap_d = lmap_q;
    for (int g = 0; g < NG; g++) begin
      if (hit_lm && idx == 6'(g / 4)) lmap_d[g*LW +: LW] = line_code[g % 4];
    end
    cmap_d = cmap_q;
    for (int i = 0; i < N_IRQ; i++) begin
      if (hit_cm && idx == 6'(i / 4)) cmap_d[i*CW +: CW] = core_code[i % 4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      lmap_q <= '0;
      cmap_q <= '0;
    end else begin
      en_q   <= en_d;
      lmap_q <= lmap_d;
      cmap_q <= cmap_d;
    end
  end

  // Raw copies kept only for readback.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < LMW; w++) lm_raw[w] <= '0;
      for (int w = 0; w < CMW; w++) cm_raw[w] <= '0;
    end else begin
      for (int w = 0; w < LMW; w++) begin
        if (hit_lm && idx == 6'(w)) lm_raw[w] <= wdata;
      end
      for (int w = 0; w < CMW; w++) begin
        if (hit_cm && idx == 6'(w)) cm_raw[w] <= wdata;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (win)
      WIN_ENABLE: begin
        for (int g = 0; g < NG; g++) begin
          if (idx == 6'(g)) rd_word = en_q[g*32 +: 32];
        end
      end
      WIN_LINEMAP: begin
        for (int w = 0; w < LMW; w++) begin
          if (idx == 6'(w)) rd_word = lm_raw[w];
        end
      end
      WIN_COREMAP: begin
        for (int w = 0; w < CMW; w++) begin
          if (idx == 6'(w)) rd_word = cm_raw[w];
        end
      end
      default: rd_word = '0;
    endcase
  end

endmodule

// File: rtl/extirq_core_slice.sv
module extirq_core_slice #(
  parameter int unsigned N_IRQ   = 64,
  parameter int unsigned N_CORE  = 4,
  parameter int unsigned N_LINE  = 4,
  parameter int unsigned CORE_ID = 0,
  localparam int unsigned NG = N_IRQ / 32,
  localparam int unsigned CW = (N_CORE > 1) ? $clog2(N_CORE) : 1,
  localparam int unsigned LW = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_IRQ-1:0]    rise,
  input  logic [N_IRQ-1:0]    fall,
  input  logic [N_IRQ-1:0]    pend_q,
  input  logic [N_IRQ-1:0]    en_q,
  input  logic [N_IRQ-1:0]    en_d,
  input  logic [N_IRQ*CW-1:0] cmap_q,
  input  logic [N_IRQ*CW-1:0] cmap_d,
  input  logic [NG*LW-1:0]    lmap_d,
  input  logic [N_IRQ-1:0]    clr_mask,
  output logic [N_IRQ-1:0]    status_q,
  output logic [N_LINE-1:0]   lines_q
);

  logic [N_IRQ-1:0]  status_d;
  logic [N_LINE-1:0] lines_d;

  // Order of effects: software clear, enable change, retarget, input edge.
  always_comb begin : p_next
    logic s, t_old, t_new, mv;
    for (int i = 0; i < N_IRQ; i++) begin
      t_old = (cmap_q[i*CW +: CW] == CW'(CORE_ID));
      t_new = (cmap_d[i*CW +: CW] == CW'(CORE_ID));
      mv    = (cmap_q[i*CW +: CW] != cmap_d[i*CW +: CW]);
      s     = status_q[i];
      if (clr_mask[i]) s = 1'b0;
      if (t_old && en_q[i] && !en_d[i]) s = 1'b0;
      if (t_old && !en_q[i] && en_d[i] && pend_q[i]) s = 1'b1;
      if (mv && pend_q[i]) begin
        if (t_old) s = 1'b0;
        if (t_new && en_d[i]) s = 1'b1;
      end
      if (fall[i] && t_new) s = 1'b0;
      if (rise[i] && en_d[i] && t_new) s = 1'b1;
      status_d[i] = s;
    end
  end

  always_comb begin
    lines_d = '0;
    for (int l = 0; l < N_LINE; l++) begin
      for (int i = 0; i < N_IRQ; i++) begin
        if (status_d[i] && lmap_d[(i/32)*LW +: LW] == LW'(l)) lines_d[l] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      lines_q  <= '0;
    end else begin
      status_q <= status_d;
      lines_q  <= lines_d;
    end
  end

endmodule

// File: rtl/extirq_router.sv
module extirq_router
  import extirq_pkg::*;
#(
  parameter int unsigned N_IRQ  = 64,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned N_LINE = 4,
  localparam int unsigned CW = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_IRQ-1:0]         irq_in,
  input  logic                     core_direct_mode,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [15:0]              req_addr,
  input  logic [31:0]              req_wdata,
  input  logic [CW-1:0]            req_core,
  output logic [31:0]              rsp_data,
  output logic [N_CORE*N_LINE-1:0] lines_out
);

  localparam int unsigned NG = N_IRQ / 32;
  localparam int unsigned LW = (N_LINE > 1) ? $clog2(N_LINE) : 1;

  logic                     in_win, wr_stb, addr_lo_unused;
  win_e                     win;
  logic [5:0]               idx;
  logic [N_IRQ-1:0]         raw_q, rise, fall, en_q, en_d, w1c_word;
  logic [NG*LW-1:0]         lmap_q, lmap_d;
  logic [N_IRQ*CW-1:0]      cmap_q, cmap_d;
  logic [N_CORE*N_IRQ-1:0]  status_all;
  logic [31:0]              cfg_rd, st_word, rd_sel;

  assign in_win         = (req_addr[15:10] == 6'd0);
  assign win            = win_e'(req_addr[9:8]);
  assign idx            = req_addr[7:2];
  assign addr_lo_unused = ^req_addr[1:0];
  assign wr_stb         = req_valid && req_write && in_win;

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= irq_in;
  end

  assign rise = irq_in & ~raw_q;
  assign fall = ~irq_in & raw_q;

  extirq_cfg #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .N_LINE(N_LINE)) u_cfg (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .win(win), .idx(idx),
    .wdata(req_wdata), .direct(core_direct_mode), .rd_word(cfg_rd),
    .en_q(en_q), .en_d(en_d), .lmap_q(lmap_q), .lmap_d(lmap_d),
    .cmap_q(cmap_q), .cmap_d(cmap_d));

  always_comb begin
    w1c_word = '0;
    for (int g = 0; g < NG; g++) begin
      if (wr_stb && win == WIN_STATUS && idx == 6'(g)) w1c_word[g*32 +: 32] = req_wdata;
    end
  end

  for (genvar k = 0; k < N_CORE; k++) begin : g_core
    logic [N_IRQ-1:0] clr_k;
    assign clr_k = (req_core == CW'(k)) ? w1c_word : '0;
    extirq_core_slice #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .N_LINE(N_LINE), .CORE_ID(k)) u_slice (
      .clk(clk), .rst(rst), .rise(rise), .fall(fall), .pend_q(raw_q),
      .en_q(en_q), .en_d(en_d), .cmap_q(cmap_q), .cmap_d(cmap_d),
      .lmap_d(lmap_d), .clr_mask(clr_k),
      .status_q(status_all[k*N_IRQ +: N_IRQ]),
      .lines_q(lines_out[k*N_LINE +: N_LINE]));
  end

  always_comb begin
    st_word = '0;
    for (int k = 0; k < N_CORE; k++) begin
      for (int g = 0; g < NG; g++) begin
        if (req_core == CW'(k) && idx == 6'(g)) st_word = status_all[k*N_IRQ + g*32 +: 32];
      end
    end
    rd_sel = (win == WIN_STATUS) ? st_word : cfg_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_data <= '0;
    end else if (req_valid && !req_write) begin
      rsp_data <= in_win ? rd_sel : 32'd0;
    end
  end

endmodule

// File: rtl/extirq_router_chk.sv
module extirq_router_chk #(
  parameter int unsigned N_IRQ  = 64,
  parameter int unsigned N_CORE = 4,
  parameter int unsigned N_LINE = 4,
  localparam int unsigned NG = N_IRQ / 32,
  localparam int unsigned CW = (N_CORE > 1) ? $clog2(N_CORE) : 1,
  localparam int unsigned LW = (N_LINE > 1) ? $clog2(N_LINE) : 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic                     req_write,
  input logic [15:0]              req_addr,
  input logic [N_IRQ-1:0]         raw_q,
  input logic [N_IRQ-1:0]         en_q,
  input logic [N_CORE*N_IRQ-1:0]  status_all,
  input logic [N_IRQ*CW-1:0]      cmap_q,
  input logic [NG*LW-1:0]         lmap_q,
  input logic [N_CORE*N_LINE-1:0] lines_out
);

  logic [N_CORE*N_LINE-1:0] lines_exp;

  always_comb begin
    lines_exp = '0;
    for (int k = 0; k < N_CORE; k++) begin
      for (int i = 0; i < N_IRQ; i++) begin
        if (status_all[k*N_IRQ + i]) begin
          for (int l = 0; l < N_LINE; l++) begin
            if (lmap_q[(i/32)*LW +: LW] == LW'(l)) lines_exp[k*N_LINE + l] = 1'b1;
          end
        end
      end
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (lines_out == '0 && status_all == '0));

  assert_lines_follow_status_R5: assert property (@(posedge clk) disable iff (rst)
    lines_out == lines_exp);

  assert_unmapped_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[15:10] != 6'd0)
      |=> ($stable(en_q) && $stable(cmap_q) && $stable(lmap_q)));

  for (genvar k = 0; k < N_CORE; k++) begin : g_k
    for (genvar i = 0; i < N_IRQ; i++) begin : g_i
      assert_status_needs_pending_R4: assert property (@(posedge clk) disable iff (rst)
        status_all[k*N_IRQ + i] |-> raw_q[i]);
      assert_status_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        status_all[k*N_IRQ + i] |-> en_q[i]);
      assert_status_on_target_R8: assert property (@(posedge clk) disable iff (rst)
        status_all[k*N_IRQ + i] |-> (cmap_q[i*CW +: CW] == CW'(k)));
    end
  end

endmodule

bind extirq_router extirq_router_chk #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .N_LINE(N_LINE)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .raw_q(raw_q), .en_q(en_q), .status_all(status_all),
  .cmap_q(cmap_q), .lmap_q(lmap_q), .lines_out(lines_out));

// File: tb/test_extirq_router.sv
module test_extirq_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        core_direct_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_core = '0;
  logic [31:0] rsp_data;
  logic [15:0] lines_out;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  logic  line_probe = 1'b0;
  logic  rd_seen = 1'b0;
  logic  pr_seen = 1'b0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  extirq_router i_extirq_router (
    .clk(clk), .rst(rst), .irq_in(irq_in), .core_direct_mode(core_direct_mode),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_core(req_core), .rsp_data(rsp_data),
    .lines_out(lines_out));

  // Monitor: pops the scoreboard when a read response or a line probe is due.
  always @(posedge clk) begin
    rd_seen <= req_valid && !req_write;
    pr_seen <= line_probe;
  end

  always @(negedge clk) begin
    if (rd_seen || pr_seen) begin
      logic [32:0] it;
      string       tg;
      logic [31:0] act;
      it  = exp_q.pop_front();
      tg  = tag_q.pop_front();
      act = it[32] ? 32'(lines_out) : rsp_data;
      checks++;
      if (act !== it[31:0]) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", tg, act, it[31:0]);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input int c);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_core = 2'(c);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input int c, input logic [31:0] e, input string t);
    exp_q.push_back({1'b0, e});
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_core = 2'(c);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_lines(input logic [15:0] e, input string t);
    exp_q.push_back({1'b1, 16'h0, e});
    tag_q.push_back(t);
    @(negedge clk);
    line_probe = 1'b1;
    @(negedge clk);
    line_probe = 1'b0;
  endtask

  task automatic set_irq(input int n, input logic v);
    @(negedge clk);
    irq_in[n] = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk_lines(16'h0000, "R1 lines after reset");
    rd(16'h0000, 0, 32'h0, "R1 enable word after reset");
    rd(16'h0200, 0, 32'h0, "R1 core map after reset");
    rd(16'h0300, 0, 32'h0, "R1 status after reset");

    // group0 -> line1, group1 -> line2; sources 0..3 -> cores 0..3
    wr(16'h0100, 32'h0000_0402, 0);
    rd(16'h0100, 0, 32'h0000_0402, "R10 line map readback");
    wr(16'h0200, 32'h0804_0201, 0);
    rd(16'h0200, 0, 32'h0804_0201, "R10 core map readback");
    wr(16'h0000, 32'h0000_000F, 0);

    set_irq(1, 1'b1);
    chk_lines(16'h0020, "R4 enabled source reaches core1 line1");
    rd(16'h0300, 1, 32'h2, "R7 status read by core1");
    rd(16'h0300, 0, 32'h0, "R7 status read by core0");
    set_irq(3, 1'b1);
    chk_lines(16'h2020, "R5 two cores lit");

    wr(16'h0300, 32'h2, 1);
    chk_lines(16'h2000, "R7 clear by owner core");
    rd(16'h0300, 1, 32'h0, "R7 status after clear");
    wr(16'h0300, 32'h8, 0);
    chk_lines(16'h2000, "R7 clear by other core has no effect");

    wr(16'h0000, 32'h0000_0007, 0);
    chk_lines(16'h0000, "R6 disable withdraws");
    wr(16'h0000, 32'h0000_000F, 0);
    chk_lines(16'h2000, "R6 re-enable replays pending");

    set_irq(32, 1'b1);
    chk_lines(16'h2000, "R4 disabled source hidden");
    wr(16'h0004, 32'h0000_0001, 0);
    chk_lines(16'h2004, "R6 enable replays group1 source on core0 line2");

    // retarget source 3 from core3 to core1
    wr(16'h0200, 32'h0204_0201, 0);
    chk_lines(16'h0024, "R8 pending source moves core3 to core1");
    rd(16'h0300, 1, 32'h8, "R8 new core status");
    rd(16'h0300, 3, 32'h0, "R8 old core status");
    wr(16'h0200, 32'h0204_0201, 0);
    chk_lines(16'h0024, "R8 unchanged entry no action");

    set_irq(3, 1'b0);
    chk_lines(16'h0004, "R4 deassert clears");

    // out-of-range one-hot byte falls back to core 0
    wr(16'h0204, 32'h0000_0010, 0);
    wr(16'h0000, 32'h0000_001F, 0);
    set_irq(4, 1'b1);
    chk_lines(16'h0006, "R3 fallback to core0");

    // out-of-range line byte falls back to line 0, live
    wr(16'h0100, 32'h0000_0410, 0);
    chk_lines(16'h0005, "R2 fallback to line0");
    rd(16'h0100, 0, 32'h0000_0410, "R10 line map readback 2");

    // direct core numbers
    @(negedge clk);
    core_direct_mode = 1'b1;
    wr(16'h0208, 32'h0000_0003, 0);
    wr(16'h0000, 32'h0000_011F, 0);
    set_irq(8, 1'b1);
    chk_lines(16'h1005, "R3 direct mode core3");
    @(negedge clk);
    core_direct_mode = 1'b0;
    wr(16'h020C, 32'h0000_0003, 0);
    wr(16'h0000, 32'h0000_111F, 0);
    set_irq(12, 1'b1);
    rd(16'h0300, 0, 32'h0000_1010, "R3 one-hot mode same byte core0");

    // unmapped accesses
    rd(16'h0400, 0, 32'h0, "R9 unmapped read");
    rd(16'h0008, 0, 32'h0, "R9 read past last enable word");
    wr(16'h0400, 32'hFFFF_FFFF, 0);
    wr(16'h8000, 32'hFFFF_FFFF, 0);
    rd(16'h0000, 0, 32'h0000_111F, "R9 enable unchanged by unmapped write");
    chk_lines(16'h1005, "R9 lines unchanged by unmapped write");

    // source 1: status cleared by software but still raw pending
    wr(16'h0000, 32'h0000_111D, 0);
    chk_lines(16'h1005, "R6 disable of cleared source");
    wr(16'h0000, 32'h0000_111F, 0);
    chk_lines(16'h1015, "R6 replay of software-cleared source");

    @(negedge clk);
    irq_in = '0;
    chk_lines(16'h0000, "R4 all deasserted");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule